// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port that sits on a simple 32-bit register bus. Software sets per-pin output values and directions, which drive the pads directly. It reads back the pad levels after they pass through a two-stage synchroniser. Each pin can also raise an interrupt. A 2-bit trigger code selects low level, high level, rising edge or falling edge. A separate per-pin override bit selects detection on any change of the pin.

Detected conditions latch into a status register whose bits software clears by writing ones. The status is ANDed with a per-pin enable mask. Two interrupt lines leave the block: one covers pins 0 to 15 and the other covers pins 16 to 31. The bus reset input is asynchronous and active low. Inside the block its release is retimed to the clock, so the block comes out of reset two clock edges after `rst_n` rises.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every writable register reads 0, both interrupt lines are low and `pad_oe` is all zeros.
- R2: `pad_out` equals the output-value register and `pad_oe` equals the direction register (1 = drive). Reading the output-value register returns the written value whatever the pad levels are.
- R3: The pad-level register returns `pad_in` once it has passed through two clock edges. Writing to the pad-level register changes no register.
- R4: Trigger codes are 00 low level, 01 high level, 10 rising edge and 11 falling edge. Pins 0-15 use the lower trigger register and pins 16-31 use the upper one, each at bits [2*(pin mod 16)+1 : 2*(pin mod 16)]. A status bit is set only when its pin's selected condition occurs.
- R5: When a pin's override bit is 1, the pin flags both rising and falling edges and its trigger code has no effect.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R7: A level condition sets its status bit again on every cycle that it persists. When a hardware set and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R8: `irq_lo` is the OR of (status AND enable) over pins 0-15, and `irq_hi` is the same OR over pins 16-31. Enable bit 1 passes the pin.
- R9: The registers sit at these byte offsets: 0x00 output value, 0x04 direction, 0x08 pad level, 0x0C lower trigger, 0x10 upper trigger, 0x14 enable, 0x18 status, 0x1C edge override. Offsets 0x20-0x3C and unaligned addresses read 0 and ignore writes.
- R10: A pad change that meets a pin's condition sets its status bit, and the matching interrupt line if enabled, on the third rising clock edge after the change. Nothing is set on the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Output value to the pads |
| pad_oe | output | 32 | Per-pin output enable |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_lo | output | 1 | Interrupt for pins 0-15 |
| irq_hi | output | 1 | Interrupt for pins 16-31 |

## Verification
Register writes take effect at the clock edge that samples the strobe, and read data follows the address without delay. The bench therefore reads back one half-cycle after each write. A pad change reaches the pad-level register after two edges and the status register after three. The bench changes pads on a falling edge, counts the rising edges from there, and samples on the following falling edge. One directed test probes the second edge to confirm that nothing has appeared early. Level persistence and clear priority are read back in the cycle right after the clearing write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  // word indices (byte offset / 4)
  localparam int WI_DOUT  = 0;
  localparam int WI_DIR   = 1;
  localparam int WI_PAD   = 2;
  localparam int WI_TRGLO = 3;
  localparam int WI_TRGHI = 4;
  localparam int WI_EN    = 5;
  localparam int WI_STAT  = 6;
  localparam int WI_ANYE  = 7;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= d_async;
      stg2_q <= stg1_q;
    end
  end

  assign q = stg2_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   lvl,
  input  logic [2*NPINS-1:0] trig_codes,
  input  logic [NPINS-1:0]   any_edge,
  output logic [NPINS-1:0]   hit
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic  rise, fall;
    trig_e code;
    assign rise = lvl[p] & ~prev_q[p];
    assign fall = ~lvl[p] & prev_q[p];
    assign code = trig_e'(trig_codes[2*p +: 2]);

    always_comb begin
      if (any_edge[p]) begin
        hit[p] = rise | fall;
      end else begin
        unique case (code)
          TRIG_LOW:  hit[p] = ~lvl[p];
          TRIG_HIGH: hit[p] = lvl[p];
          TRIG_RISE: hit[p] = rise;
          TRIG_FALL: hit[p] = fall;
          default:   hit[p] = 1'b0;
        endcase
      end
    end
  end

  // override pin reports only a change between two successive samples
  AST_ANYEDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit & any_edge) & ~(lvl ^ prev_q)) == '0); // R5
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]   pad_lvl,
  input  logic [NPINS-1:0]   hit,
  output logic [NPINS-1:0]   dout,
  output logic [NPINS-1:0]   dir,
  output logic [2*NPINS-1:0] trig_codes,
  output logic [NPINS-1:0]   any_edge,
  output logic [NPINS-1:0]   stat,
  output logic [NPINS-1:0]   enable
);
  localparam int HALF   = NPINS / 2;
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] A_DOUT  = WORD_W'(WI_DOUT);
  localparam logic [WORD_W-1:0] A_DIR   = WORD_W'(WI_DIR);
  localparam logic [WORD_W-1:0] A_PAD   = WORD_W'(WI_PAD);
  localparam logic [WORD_W-1:0] A_TRGLO = WORD_W'(WI_TRGLO);
  localparam logic [WORD_W-1:0] A_TRGHI = WORD_W'(WI_TRGHI);
  localparam logic [WORD_W-1:0] A_EN    = WORD_W'(WI_EN);
  localparam logic [WORD_W-1:0] A_STAT  = WORD_W'(WI_STAT);
  localparam logic [WORD_W-1:0] A_ANYE  = WORD_W'(WI_ANYE);

  logic [NPINS-1:0]  dout_q, dout_d, dir_q, dir_d, en_q, en_d;
  logic [NPINS-1:0]  anye_q, anye_d, stat_q, stat_d, stat_clr;
  logic [2*HALF-1:0] trglo_q, trglo_d, trghi_q, trghi_d;
  logic [WORD_W-1:0] word;
  logic              aligned, wr_en;

  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_en   = bus_en & bus_we & aligned;

  // next state
  always_comb begin
    dout_d   = dout_q;
    dir_d    = dir_q;
    en_d     = en_q;
    anye_d   = anye_q;
    trglo_d  = trglo_q;
    trghi_d  = trghi_q;
    stat_clr = '0;
    if (wr_en) begin
      case (word)
        A_DOUT:  dout_d   = bus_wdata[NPINS-1:0];
        A_DIR:   dir_d    = bus_wdata[NPINS-1:0];
        A_TRGLO: trglo_d  = bus_wdata[2*HALF-1:0];
        A_TRGHI: trghi_d  = bus_wdata[2*HALF-1:0];
        A_EN:    en_d     = bus_wdata[NPINS-1:0];
        A_STAT:  stat_clr = bus_wdata[NPINS-1:0];
        A_ANYE:  anye_d   = bus_wdata[NPINS-1:0];
        default: ;
      endcase
    end
    // hardware set wins over a simultaneous clear
    stat_d = (stat_q & ~stat_clr) | hit;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      dir_q   <= '0;
      en_q    <= '0;
      anye_q  <= '0;
      trglo_q <= '0;
      trghi_q <= '0;
      stat_q  <= '0;
    end else begin
      dout_q  <= dout_d;
      dir_q   <= dir_d;
      en_q    <= en_d;
      anye_q  <= anye_d;
      trglo_q <= trglo_d;
      trghi_q <= trghi_d;
      stat_q  <= stat_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (word)
        A_DOUT:  bus_rdata[NPINS-1:0]  = dout_q;
        A_DIR:   bus_rdata[NPINS-1:0]  = dir_q;
        A_PAD:   bus_rdata[NPINS-1:0]  = pad_lvl;
        A_TRGLO: bus_rdata[2*HALF-1:0] = trglo_q;
        A_TRGHI: bus_rdata[2*HALF-1:0] = trghi_q;
        A_EN:    bus_rdata[NPINS-1:0]  = en_q;
        A_STAT:  bus_rdata[NPINS-1:0]  = stat_q;
        A_ANYE:  bus_rdata[NPINS-1:0]  = anye_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign dout       = dout_q;
  assign dir        = dir_q;
  assign trig_codes = {trghi_q, trglo_q};
  assign any_edge   = anye_q;
  assign stat       = stat_q;
  assign enable     = en_q;

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr != '0) |=> ((stat_q & $past(stat_clr & ~hit)) == '0)); // R6
  AST_HIT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((stat_q & $past(hit)) == $past(hit))); // R7
  AST_SET_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat_q & ~$past(stat_q) & ~$past(hit)) == '0)); // R4
  AST_PAD_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == A_PAD) |=> ($stable(dout_q) && $stable(dir_q) && $stable(en_q)
      && $stable(anye_q) && $stable(trglo_q) && $stable(trghi_q))); // R3
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int HALF = NPINS / 2;

  logic [1:0]         rst_pipe_q;
  logic               rst_sync_n;
  logic [NPINS-1:0]   lvl, hit, stat, enable, any_edge;
  logic [2*NPINS-1:0] trig_codes;
  logic [NPINS-1:0]   pend;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  gpio_irq_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_async(pad_in), .q(lvl)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst_n(rst_sync_n), .lvl(lvl), .trig_codes(trig_codes),
    .any_edge(any_edge), .hit(hit)
  );

  gpio_irq_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_lvl(lvl), .hit(hit), .dout(pad_out), .dir(pad_oe),
    .trig_codes(trig_codes), .any_edge(any_edge), .stat(stat), .enable(enable)
  );

  assign pend   = stat & enable;
  assign irq_lo = |pend[HALF-1:0];
  assign irq_hi = |pend[NPINS-1:HALF];

  AST_NO_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (enable == '0) |-> (!irq_lo && !irq_hi)); // R8
endmodule

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pad_in;
  logic [31:0] pad_out, pad_oe;
  logic        bus_en, bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_lo, irq_hi;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_port uut (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // {pin[4:0], code[1:0], override, before, after, expect}
  localparam logic [10:0] VEC [0:9] = '{
    {5'd3,  2'b10, 1'b0, 1'b0, 1'b1, 1'b1},  // rising fires
    {5'd3,  2'b10, 1'b0, 1'b1, 1'b0, 1'b0},  // rising ignores fall
    {5'd20, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1},  // falling fires
    {5'd20, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0},  // falling ignores rise
    {5'd7,  2'b01, 1'b0, 1'b0, 1'b1, 1'b1},  // high level
    {5'd7,  2'b00, 1'b0, 1'b1, 1'b0, 1'b1},  // low level
    {5'd31, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0},  // low level, stays high
    {5'd16, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1},  // override, rise
    {5'd16, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1},  // override, fall
    {5'd15, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0}   // override masks low-level code
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; pad_in = '0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      if (a == 2 || a == 6) continue;
      rd(6'(a*4), v);
      check(v, 32'h0, "R1");
    end
    check({30'd0, irq_hi, irq_lo}, 32'h0, "R1");
    check(pad_oe, 32'h0, "R1");

    // R2 output value and direction
    wr(6'h00, 32'hA5C3_0F18);
    wr(6'h04, 32'hFFFF_0000);
    check(pad_out, 32'hA5C3_0F18, "R2");
    check(pad_oe, 32'hFFFF_0000, "R2");
    pad_in = 32'h1234_5678;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(6'h00, v);
    check(v, 32'hA5C3_0F18, "R2");

    // R3 pad level and ignored write
    rd(6'h08, v);
    check(v, 32'h1234_5678, "R3");
    wr(6'h08, 32'hFFFF_FFFF);
    rd(6'h08, v);
    check(v, 32'h1234_5678, "R3");
    rd(6'h00, v);
    check(v, 32'hA5C3_0F18, "R3");

    // R9 unmapped and unaligned
    wr(6'h24, 32'hFFFF_FFFF);
    rd(6'h24, v);
    check(v, 32'h0, "R9");
    wr(6'h05, 32'h0000_00FF);
    rd(6'h04, v);
    check(v, 32'hFFFF_0000, "R9");
    rd(6'h01, v);
    check(v, 32'h0, "R9");

    // vector table: R4 R5 R8
    for (int i = 0; i < 10; i++) begin
      logic [4:0]  pin;
      logic [1:0]  code;
      logic        ovr, bef, aft, exp;
      logic [31:0] pm;
      {pin, code, ovr, bef, aft, exp} = VEC[i];
      pm = 32'd1 << pin;
      @(negedge clk);
      pad_in = '0;
      pad_in[pin] = bef;
      wr(pin < 16 ? 6'h0C : 6'h10, {30'd0, code} << (2 * (pin % 16)));
      wr(6'h1C, ovr ? pm : 32'h0);
      wr(6'h14, pm);
      repeat (4) @(posedge clk);
      wr(6'h18, 32'hFFFF_FFFF);
      pad_in[pin] = aft;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rd(6'h18, v);
      check({31'd0, v[pin]}, {31'd0, exp}, ovr ? "R5" : "R4");
      check({31'd0, irq_lo}, {31'd0, exp & (pin < 16)}, "R8");
      check({31'd0, irq_hi}, {31'd0, exp & (pin >= 16)}, "R8");
    end

    // R10 latency on pin 5, high level
    wr(6'h1C, 32'h0);
    wr(6'h0C, 32'h0000_0400);
    wr(6'h14, 32'h0000_0020);
    @(negedge clk) pad_in = '0;
    repeat (4) @(posedge clk);
    wr(6'h18, 32'hFFFF_FFFF);
    pad_in[5] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check({31'd0, irq_lo}, 32'd0, "R10");
    @(posedge clk);
    @(negedge clk);
    check({31'd0, irq_lo}, 32'd1, "R10");

    // R6 writing zero keeps status; writing one clears (pin 5 back to rising)
    wr(6'h0C, 32'h0000_0800);
    wr(6'h18, 32'h0000_0000);
    rd(6'h18, v);
    check({31'd0, v[5]}, 32'd1, "R6");
    wr(6'h18, 32'h0000_0020);
    rd(6'h18, v);
    check({31'd0, v[5]}, 32'd0, "R6");

    // R7 level persists through clear, clears once gone (pin 9 low level)
    wr(6'h0C, 32'h0);
    wr(6'h14, 32'h0000_0200);
    @(negedge clk) pad_in[9] = 1'b0;
    repeat (4) @(posedge clk);
    wr(6'h18, 32'h0000_0200);
    rd(6'h18, v);
    check({31'd0, v[9]}, 32'd1, "R7");
    check({31'd0, irq_lo}, 32'd1, "R7");
    pad_in[9] = 1'b1;
    repeat (3) @(posedge clk);
    wr(6'h18, 32'h0000_0200);
    rd(6'h18, v);
    check({31'd0, v[9]}, 32'd0, "R7");
    check({31'd0, irq_lo}, 32'd0, "R7");

    finish_run();
  end
endmodule